// File: doc/BRIEF.md
# Clock Control Register File

This block is the software-visible register bank of a clock and reset controller. A bus master reaches it through a simple word-addressed port: a one-cycle strobe, a write enable, a 12-bit byte address covering a 4 KiB window, and 32-bit write data. The bank stores clock gating masks, a source-select word, three divider words, peripheral reset words, three watchdog reset-control words, four software reset-control words, a core reset-control word, a bus frequency word and four PLL control words. It does not drive any real PLL, mux or divider.

A cold reset (active-low `rst_n`) loads each word with a fixed value. Writes to the four PLL words follow a lock-status rule. Bit 12 requests power-down. Bit 31 shows lock. Bit 30 is a sticky loss-of-lock flag that the bus clears by writing one to it. One word is a write-only software reset trigger. Two words in the map are left unassigned. Any misaligned, unassigned or out-of-range access raises a one-cycle error pulse. Read data comes back on the cycle after the strobe, together with a valid pulse.

Top module: `clk_ctrl_regs`

## Requirements
- R1: Word offsets are the byte address divided by four: 0x00 gate A, 0x04 source select, 0x08 divider A, 0x0C PLL A, 0x10 PLL B, 0x14 soft reset trigger, 0x20 periph reset A, 0x24 periph reset B, 0x28 gate B, 0x2C divider B, 0x30 gate C, 0x34 periph reset C, 0x38/0x3C/0x40 watchdog reset 0..2, 0x44..0x50 soft reset control 0..3, 0x54 PLL C, 0x58 divider C, 0x5C core reset control, 0x60 PLL D, 0x64 bus frequency. A cold reset loads these values:
  - all three gates and all three watchdog words: 0xFFFFFFFF
  - source select: 0x004AAAAA
  - divider A: 0x5413F855
  - divider B: 0xAA4F8F9F
  - PLL A, B, C, D: 0x80222101, 0x80202101, 0x80C02105, 0x81228606
  - periph reset A, B, C: 0x00001000, 0x80000000, 0x03000000
  - soft reset control 0: 0x00000003
  - core reset control: 0x04000003
  - bus frequency: 0x000000C8
  - every other word: zero
- R2: An ordinary word reads back exactly the last value written. A read strobe in cycle N gives `rd_valid` high and `rd_data` valid in cycle N+1.
- R3: A write to a PLL word with bit 12 set stores the written value with bit 31 forced to 0 and bit 30 forced to 1.
- R4: A write to a PLL word with bit 12 clear stores the written value with bit 31 forced to 1. Bit 30 becomes 0 if the write carries a 1 there, and otherwise keeps its previous value.
- R5: The soft reset trigger at 0x14 always reads zero and flags an error on a read. A write to it is accepted without error.
- R6: The unassigned offsets 0x18 and 0x1C read zero and flag an error. Writes to them change no word.
- R7: Aligned offsets from 0x68 to 0xFFC read zero and flag an error. Writes to them change no word.
- R8: An address with either of bits 1:0 set is an error. A read returns zero and a write changes no word.
- R9: `bus_err` is high for exactly the one cycle after a bad strobe and is low otherwise. `rd_valid` is high only in the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| bus_err | output | 1 | One-cycle error pulse for a bad access |

## Verification
The hardest state to reach from the ports is a PLL word whose loss flag is set while the PLL is running again. To get there, the stimulus first writes a power-down request, then writes a normal-mode value with bit 30 clear, and reads the word back to confirm the flag has stayed set. Only after that does it write a one to bit 30 to clear the flag. Random traffic then mixes PLL words with holes, out-of-range and misaligned addresses. A bench model tracks every word, so any stray write to a bad address shows up on a later read.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    localparam int DATA_W   = 32;
    localparam int NUM_WORDS = 26;
    localparam int LOCK_BIT = 31;
    localparam int LOSS_BIT = 30;
    localparam int PDN_BIT  = 12;

    localparam int IDX_PLL_A   = 3;
    localparam int IDX_PLL_B   = 4;
    localparam int IDX_SOFTRST = 5;
    localparam int IDX_PLL_C   = 21;
    localparam int IDX_PLL_D   = 24;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_PLAIN = 2'd1,
        KIND_PLL   = 2'd2,
        KIND_WO    = 2'd3
    } word_kind_t;

    function automatic word_kind_t kind_of(input int i);
        if (i < 0 || i >= NUM_WORDS) return KIND_NONE;
        case (i)
            6, 7:                                        return KIND_NONE;
            IDX_SOFTRST:                                 return KIND_WO;
            IDX_PLL_A, IDX_PLL_B, IDX_PLL_C, IDX_PLL_D:  return KIND_PLL;
            default:                                     return KIND_PLAIN;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] cold_value(input int i);
        case (i)
            0, 10, 12, 14, 15, 16: return 32'hFFFF_FFFF;
            1:  return 32'h004A_AAAA;
            2:  return 32'h5413_F855;
            3:  return 32'h8022_2101;
            4:  return 32'h8020_2101;
            8:  return 32'h0000_1000;
            9:  return 32'h8000_0000;
            11: return 32'hAA4F_8F9F;
            13: return 32'h0300_0000;
            17: return 32'h0000_0003;
            21: return 32'h80C0_2105;
            23: return 32'h0400_0003;
            24: return 32'h8122_8606;
            25: return 32'h0000_00C8;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/ccr_decode.sv
module ccr_decode #(
    parameter int AW = 12,
    parameter int NW = ccr_pkg::NUM_WORDS,
    localparam int IW = $clog2(NW)
) (
    input  logic [AW-1:0]            addr,
    output logic [IW-1:0]            idx,
    output ccr_pkg::word_kind_t      kind
);
    logic [AW-3:0] word;

    always_comb begin
        word = addr[AW-1:2];
        idx  = word[IW-1:0];
        if (addr[1:0] != 2'b00)
            kind = ccr_pkg::KIND_NONE;
        else if (int'(word) >= NW)
            kind = ccr_pkg::KIND_NONE;
        else
            kind = ccr_pkg::kind_of(int'(word));
    end
endmodule

// File: rtl/ccr_pll_rule.sv
module ccr_pll_rule #(
    parameter int DW = ccr_pkg::DATA_W
) (
    input  logic [DW-1:0] wr_word,
    input  logic          prev_loss,
    output logic [DW-1:0] next_word
);
    always_comb begin
        next_word = wr_word;
        if (wr_word[ccr_pkg::PDN_BIT]) begin
            next_word[ccr_pkg::LOCK_BIT] = 1'b0;
            next_word[ccr_pkg::LOSS_BIT] = 1'b1;
        end else begin
            next_word[ccr_pkg::LOCK_BIT] = 1'b1;
            next_word[ccr_pkg::LOSS_BIT] = prev_loss & ~wr_word[ccr_pkg::LOSS_BIT];
        end
    end
endmodule

// File: rtl/clk_ctrl_regs.sv
module clk_ctrl_regs #(
    parameter int AW = 12,
    parameter int DW = ccr_pkg::DATA_W,
    parameter int NW = ccr_pkg::NUM_WORDS,
    localparam int IW = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          bus_err
);
    typedef struct packed {
        logic [NW-1:0][DW-1:0] regs;
        logic [DW-1:0]         rdata;
        logic                  rvalid;
        logic                  err;
    } state_t;

    state_t              st_d, st_q;
    logic [IW-1:0]       acc_idx;
    ccr_pkg::word_kind_t acc_kind;
    logic [DW-1:0]       pll_word;

    ccr_decode #(.AW(AW), .NW(NW)) decode_i (
        .addr (bus_addr),
        .idx  (acc_idx),
        .kind (acc_kind)
    );

    ccr_pll_rule #(.DW(DW)) pll_rule_i (
        .wr_word   (bus_wdata),
        .prev_loss (st_q.regs[acc_idx][ccr_pkg::LOSS_BIT]),
        .next_word (pll_word)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.err    = 1'b0;
        if (bus_req) begin
            st_d.err = (acc_kind == ccr_pkg::KIND_NONE);
            if (bus_we) begin
                case (acc_kind)
                    ccr_pkg::KIND_PLAIN: st_d.regs[acc_idx] = bus_wdata;
                    ccr_pkg::KIND_PLL:   st_d.regs[acc_idx] = pll_word;
                    ccr_pkg::KIND_WO:    st_d.regs[acc_idx] = '0;
                    default: ;
                endcase
            end else begin
                st_d.rvalid = 1'b1;
                if (acc_kind == ccr_pkg::KIND_PLAIN || acc_kind == ccr_pkg::KIND_PLL)
                    st_d.rdata = st_q.regs[acc_idx];
                else
                    st_d.rdata = '0;
                if (acc_kind == ccr_pkg::KIND_WO)
                    st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++)
                st_q.regs[i] <= ccr_pkg::cold_value(i);
            st_q.rdata  <= '0;
            st_q.rvalid <= 1'b0;
            st_q.err    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rdata;
    assign rd_valid = st_q.rvalid;
    assign bus_err  = st_q.err;

    // R2
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> rd_valid);

    // R9
    rd_only_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !rd_valid);

    // R7
    out_of_range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && int'(bus_addr) >= NW*4) |=> (bus_err && (rd_valid -> rd_data == '0)));

    // R3
    pll_powerdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && int'(bus_addr) == ccr_pkg::IDX_PLL_A*4 && bus_wdata[ccr_pkg::PDN_BIT])
        |=> (!st_q.regs[ccr_pkg::IDX_PLL_A][ccr_pkg::LOCK_BIT] && st_q.regs[ccr_pkg::IDX_PLL_A][ccr_pkg::LOSS_BIT]));

    // R5
    softrst_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && int'(bus_addr) == ccr_pkg::IDX_SOFTRST*4) |=> (bus_err && rd_data == '0));

    // R9
    idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_err);
endmodule

// File: tb/clk_ctrl_regs_tb.sv
`timescale 1ns/1ps
module clk_ctrl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        bus_err;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] mdl [0:25];

    always #10 clk = ~clk;

    clk_ctrl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .bus_err(bus_err)
    );

    // 0 none, 1 plain, 2 pll, 3 write-only (R1, R5..R8)
    function automatic int exp_kind(input logic [11:0] a);
        int w;
        if (a[1:0] != 2'b00) return 0;
        w = int'(a) / 4;
        if (w >= 26 || w == 6 || w == 7) return 0;
        if (w == 5) return 3;
        if (w == 3 || w == 4 || w == 21 || w == 24) return 2;
        return 1;
    endfunction

    function automatic logic [31:0] exp_cold(input int i);
        case (i)
            0, 10, 12, 14, 15, 16: return 32'hFFFFFFFF;
            1:  return 32'h004AAAAA;
            2:  return 32'h5413F855;
            3:  return 32'h80222101;
            4:  return 32'h80202101;
            8:  return 32'h00001000;
            9:  return 32'h80000000;
            11: return 32'hAA4F8F9F;
            13: return 32'h03000000;
            17: return 32'h00000003;
            21: return 32'h80C02105;
            23: return 32'h04000003;
            24: return 32'h81228606;
            25: return 32'h000000C8;
            default: return 32'h0;
        endcase
    endfunction

    // R3, R4
    function automatic logic [31:0] exp_pll(input logic [31:0] d, input logic old_loss);
        logic [31:0] r;
        r = d;
        if (d[12]) begin
            r[31] = 1'b0; r[30] = 1'b1;
        end else begin
            r[31] = 1'b1; r[30] = old_loss & ~d[30];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input string tag);
        int k;
        int w;
        k = exp_kind(a);
        w = int'(a) / 4;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        check(bus_err === (k == 0), {tag, " R9 write err"}, 32'(bus_err), 32'(k == 0));
        check(rd_valid === 1'b0, {tag, " R9 no rd_valid on write"}, 32'(rd_valid), 32'h0);
        if (k == 1) mdl[w] = d;
        else if (k == 2) mdl[w] = exp_pll(d, mdl[w][30]);
    endtask

    task automatic bus_read(input logic [11:0] a, input string tag);
        int k;
        logic [31:0] e;
        k = exp_kind(a);
        e = (k == 1 || k == 2) ? mdl[int'(a) / 4] : 32'h0;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        check(rd_valid === 1'b1, {tag, " R2 rd_valid"}, 32'(rd_valid), 32'h1);
        check(rd_data === e, tag, rd_data, e);
        check(bus_err === (k == 0 || k == 3), {tag, " err"}, 32'(bus_err), 32'(k == 0 || k == 3));
    endtask

    initial begin
        void'($urandom(32'h5EED_C10C));
        for (int i = 0; i < 26; i++) mdl[i] = exp_cold(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid === 1'b0 && bus_err === 1'b0, "R1 reset outputs idle", {30'h0, rd_valid, bus_err}, 32'h0);

        // R1: every word after cold reset
        for (int i = 0; i < 26; i++) bus_read(12'(i * 4), "R1 cold value");
        @(negedge clk);
        check(rd_valid === 1'b0 && bus_err === 1'b0, "R9 idle after read", {30'h0, rd_valid, bus_err}, 32'h0);

        // R2: plain readback, gates included
        bus_write(12'h000, 32'h1234_5678, "R2");
        bus_read(12'h000, "R2 gate readback");
        bus_write(12'h064, 32'hDEAD_BEEF, "R2");
        bus_read(12'h064, "R2 freq readback");

        // R3 then R4: loss flag sticky while running
        bus_write(12'h00C, 32'h0000_1ABC, "R3");
        bus_read(12'h00C, "R3 powerdown word");
        bus_write(12'h00C, 32'h0000_0ABC, "R4");
        bus_read(12'h00C, "R4 loss kept");
        bus_write(12'h00C, 32'h4000_0ABC, "R4");
        bus_read(12'h00C, "R4 loss cleared");
        bus_write(12'h060, 32'h7FFF_EFFF, "R4");
        bus_read(12'h060, "R4 lock forced");

        // R5 write-only trigger
        bus_write(12'h014, 32'hFFFF_FFFF, "R5");
        bus_read(12'h014, "R5 trigger reads zero");

        // R6 holes
        bus_write(12'h018, 32'hAAAA_5555, "R6");
        bus_write(12'h01C, 32'h5555_AAAA, "R6");
        bus_read(12'h018, "R6 hole read");
        bus_read(12'h01C, "R6 hole read");
        bus_read(12'h014, "R6 neighbour untouched");
        bus_read(12'h020, "R6 neighbour untouched");

        // R7 out of range
        bus_write(12'h068, 32'h0BAD_0BAD, "R7");
        bus_write(12'hFFC, 32'h0BAD_0BAD, "R7");
        bus_read(12'h068, "R7 first beyond");
        bus_read(12'hFFC, "R7 last in window");
        bus_read(12'h064, "R7 last word untouched");

        // R8 misaligned
        bus_write(12'h005, 32'hCAFE_F00D, "R8");
        bus_read(12'h006, "R8 misaligned read");
        bus_read(12'h004, "R8 target untouched");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int r;
            logic [11:0] a;
            logic [31:0] d;
            r = int'($urandom % 40);
            if (r < 28) a = 12'(r * 4);
            else if (r < 34) a = 12'(104 + 4 * int'($urandom % 998));
            else a = 12'(4 * int'($urandom % 26) + 1 + int'($urandom % 3));
            d = $urandom;
            if ($urandom % 3 == 0) d[12] = 1'b0;
            if ($urandom % 2 == 0) bus_write(a, d, "R2/R3/R4 random");
            else bus_read(a, "R2..R8 random");
        end
        for (int i = 0; i < 26; i++) bus_read(12'(i * 4), "R2 final sweep");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule